// File: doc/BRIEF.md
# Ultra DMA Burst Engine

This block is the device end of an Ultra DMA transfer on a 16-bit parallel ATA data bus. A local controller starts a burst with a direction and a word count. The engine then raises its DMA request and waits for the host's active-low acknowledge. It moves words between the bus and a pair of simple FIFO-style ports: one side pushes received words, the other pops words to send. It drops the request when the burst cannot continue, and it returns to idle when the host raises the stop line.

In the host-to-device direction, the host toggles its strobe once per word, and both edges count. The strobe and the bus word pass through the same synchroniser into the core clock, and an edge detector turns each toggle into a single push. The device paces the host with a registered active-low ready output. In the device-to-host direction, the engine pops a word, drives it onto the bus, and toggles its own strobe on the following cycle. It waits a programmable gap before the next word and holds off while the host's active-low ready is high. A 16-bit running sum of every word moved is available when the burst ends.

Top module: `udma_burst_engine`

## Requirements
- R1: After reset, dmarq is 0, ddmardy_n is 1, dd_oe is 0, dstrobe is 1 and busy is 0.
- R2: A start pulse with a non-zero word_cnt raises dmarq in the next cycle. A start with word_cnt 0 is ignored. No word moves while dmack_n stays high.
- R3: In the host-to-device direction (dir_in = 0), every rising and every falling hstrobe edge pushes exactly one word. Each push carries the dd_in value present with that edge, and words are pushed in arrival order.
- R4: ddmardy_n is low only during a host-to-device transfer. When fifo_full is seen, dmarq falls, ddmardy_n goes high, and later strobe edges push nothing.
- R5: In the device-to-host direction (dir_in = 1), dstrobe toggles once per popped word. At each toggle, dd_out already holds that word, and dd_oe is 1.
- R6: While hrdy_n is high, no word is popped and dstrobe stops toggling. The burst resumes when hrdy_n returns low.
- R7: If fifo_empty is seen in the device-to-host direction while words remain, dmarq falls and no further word is sent. busy stays high until stop arrives.
- R8: When the word count reaches zero, dmarq falls and no further word moves.
- R9: When stop is sampled high during a transfer, or while waiting after one, the engine goes idle: done pulses for one cycle with busy low. Every word that was popped has already been strobed out.
- R10: When done pulses, sum_o equals the 16-bit modular sum of all words moved in the burst. sum_o holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a burst |
| dir_in | input | 1 | Burst direction: 0 host-to-device, 1 device-to-host |
| word_cnt | input | 16 | Number of words in the burst |
| dmarq | output | 1 | DMA request to the host |
| dmack_n | input | 1 | DMA acknowledge from the host, active low |
| stop | input | 1 | Host stop line, ends the burst |
| hstrobe | input | 1 | Host data strobe, both edges valid |
| hrdy_n | input | 1 | Host ready for device-to-host data, active low |
| dd_in | input | 16 | Data bus as driven by the host |
| ddmardy_n | output | 1 | Device ready for host-to-device data, active low |
| dstrobe | output | 1 | Device data strobe, both edges valid |
| dd_out | output | 16 | Data bus value driven by the device |
| dd_oe | output | 1 | Device drives the data bus |
| push_en | output | 1 | Write a received word to the sink FIFO |
| push_data | output | 16 | Received word |
| fifo_full | input | 1 | Sink FIFO cannot accept a word |
| pop_en | output | 1 | Take the current word from the source FIFO |
| pop_data | input | 16 | Head word of the source FIFO |
| fifo_empty | input | 1 | Source FIFO has no word |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse when the burst ends |
| sum_o | output | 16 | Running 16-bit sum of the words moved |

## Verification
Each result has a fixed latency:
- dmarq rises one cycle after start, and done pulses one cycle after stop is sampled.
- A host strobe edge produces its push two cycles after it is driven, because of the synchroniser.
- A popped word reaches dstrobe one cycle after the pop. A change on hrdy_n takes effect only after two synchroniser cycles plus one strobe still in flight.

The bench drives inputs on the falling clock edge and records pushes, pops and strobe toggles at mid-cycle. Every host word is held four cycles. Each pause or stop check waits out that pipeline before it compares, and then waits a further window to show that nothing moves.

// File: rtl/udma_pkg.sv
package udma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_HOLD = 2'd3
    } udma_st_e;

endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[i] <= RST;
                else        st_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[i] <= RST;
                else        st_q[i] <= st_q[i-1];
            end
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/udma_edge_sync.sv
module udma_edge_sync #(
    parameter int DW     = 16,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_in,
    input  logic [DW-1:0] data_in,
    output logic          edge_o,
    output logic [DW-1:0] data_o
);
    logic [DW:0] bundle_s;
    logic        stb_last_q;

    // strobe and data share one chain so they stay aligned
    udma_sync #(.W(DW+1), .STAGES(STAGES), .RST('0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({stb_in, data_in}),
        .q     (bundle_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_last_q <= 1'b0;
        else        stb_last_q <= bundle_s[DW];
    end

    assign edge_o = bundle_s[DW] ^ stb_last_q;
    assign data_o = bundle_s[DW-1:0];
endmodule

// File: rtl/udma_sum.sv
module udma_sum #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] val,
    output logic [DW-1:0] sum_o
);
    logic [DW-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sum_q <= '0;
        else if (clr) sum_q <= '0;
        else if (en)  sum_q <= sum_q + val;
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/udma_burst_engine.sv
module udma_burst_engine #(
    parameter int DW      = 16,
    parameter int CW      = 16,
    parameter int SYNC    = 2,
    parameter int STB_GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_in,
    input  logic [CW-1:0] word_cnt,
    output logic          dmarq,
    input  logic          dmack_n,
    input  logic          stop,
    input  logic          hstrobe,
    input  logic          hrdy_n,
    input  logic [DW-1:0] dd_in,
    output logic          ddmardy_n,
    output logic          dstrobe,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic          push_en,
    output logic [DW-1:0] push_data,
    input  logic          fifo_full,
    output logic          pop_en,
    input  logic [DW-1:0] pop_data,
    input  logic          fifo_empty,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] sum_o
);
    import udma_pkg::*;

    localparam int GW = $clog2(STB_GAP + 1);
    localparam logic [GW-1:0] GAP_LD = GW'(STB_GAP);
    localparam logic [CW-1:0] LAST   = CW'(1);

    typedef struct packed {
        udma_st_e      st;
        logic          dir;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dout;
        logic          dstb;
        logic          pend;
        logic [GW-1:0] gap;
        logic          rdy_n;
        logic          done;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, dir: 1'b0, cnt: '0, dout: '0,
                                 dstb: 1'b1, pend: 1'b0, gap: '0,
                                 rdy_n: 1'b1, done: 1'b0};

    eng_t          eng_d, eng_q;
    logic          rx_edge;
    logic [DW-1:0] rx_word;
    logic          hrdy_s;
    logic          sum_clr, sum_en;
    logic [DW-1:0] sum_val;

    udma_edge_sync #(.DW(DW), .STAGES(SYNC)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_in  (hstrobe),
        .data_in (dd_in),
        .edge_o  (rx_edge),
        .data_o  (rx_word)
    );

    udma_sync #(.W(1), .STAGES(SYNC), .RST(1'b1)) u_hrdy (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hrdy_n),
        .q     (hrdy_s)
    );

    udma_sum #(.DW(DW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sum_clr),
        .en    (sum_en),
        .val   (sum_val),
        .sum_o (sum_o)
    );

    always_comb begin
        eng_d     = eng_q;
        eng_d.done = 1'b0;
        push_en   = 1'b0;
        pop_en    = 1'b0;
        sum_clr   = 1'b0;
        sum_en    = 1'b0;
        sum_val   = rx_word;

        if (eng_q.gap != '0) eng_d.gap = eng_q.gap - 1'b1;

        // a word placed on the bus last cycle gets its strobe edge now
        if (eng_q.pend) begin
            eng_d.dstb = ~eng_q.dstb;
            eng_d.pend = 1'b0;
            eng_d.gap  = GAP_LD;
        end

        case (eng_q.st)
            ST_IDLE: begin
                if (start && word_cnt != '0) begin
                    eng_d.st  = ST_REQ;
                    eng_d.dir = dir_in;
                    eng_d.cnt = word_cnt;
                    sum_clr   = 1'b1;
                end
            end
            ST_REQ: begin
                if (!dmack_n) eng_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (stop && !eng_q.pend) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.done = 1'b1;
                end else if (!eng_q.dir) begin
                    if (fifo_full) begin
                        eng_d.st = ST_HOLD;
                    end else if (rx_edge) begin
                        push_en   = 1'b1;
                        sum_en    = 1'b1;
                        eng_d.cnt = eng_q.cnt - 1'b1;
                        if (eng_q.cnt == LAST) eng_d.st = ST_HOLD;
                    end
                end else if (!eng_q.pend && eng_q.gap == '0 && !hrdy_s) begin
                    if (fifo_empty) begin
                        eng_d.st = ST_HOLD;
                    end else begin
                        pop_en     = 1'b1;
                        sum_en     = 1'b1;
                        sum_val    = pop_data;
                        eng_d.dout = pop_data;
                        eng_d.pend = 1'b1;
                        eng_d.cnt  = eng_q.cnt - 1'b1;
                        if (eng_q.cnt == LAST) eng_d.st = ST_HOLD;
                    end
                end
            end
            default: begin
                if (stop && !eng_q.pend) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.done = 1'b1;
                end
            end
        endcase

        eng_d.rdy_n = !(eng_d.st == ST_XFER && !eng_d.dir && !fifo_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign dmarq     = (eng_q.st == ST_REQ) || (eng_q.st == ST_XFER);
    assign busy      = (eng_q.st != ST_IDLE);
    assign dd_oe     = eng_q.dir && (eng_q.st == ST_XFER || eng_q.st == ST_HOLD);
    assign ddmardy_n = eng_q.rdy_n;
    assign dstrobe   = eng_q.dstb;
    assign dd_out    = eng_q.dout;
    assign done      = eng_q.done;
    assign push_data = rx_word;
endmodule

// File: rtl/udma_burst_chk.sv
module udma_burst_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic stop,
    input logic hrdy_n,
    input logic dmarq,
    input logic ddmardy_n,
    input logic dstrobe,
    input logic dd_oe,
    input logic push_en,
    input logic pop_en,
    input logic busy,
    input logic done
);
    // R2
    rq_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmarq) |-> $past(start));

    // R4
    ready_out_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ddmardy_n |-> (dmarq && !dd_oe));

    // R5
    strobe_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dstrobe != $past(dstrobe)) |-> dd_oe);

    // R6 (depth matches the default two-stage synchroniser)
    pause_blocks_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hrdy_n, 2) |-> !pop_en);

    // R9
    done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(stop));

    // R9
    idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !dmarq));

    // R3
    one_way_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_en && pop_en));
endmodule

bind udma_burst_engine udma_burst_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .hrdy_n    (hrdy_n),
    .dmarq     (dmarq),
    .ddmardy_n (ddmardy_n),
    .dstrobe   (dstrobe),
    .dd_oe     (dd_oe),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_udma_burst_engine.sv
module tb_udma_burst_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_in = 1'b0;
    logic [15:0] word_cnt = '0;
    logic        dmack_n = 1'b1, stop = 1'b0, hstrobe = 1'b0, hrdy_n = 1'b1;
    logic [15:0] dd_in = '0;
    logic        fifo_full = 1'b0;
    logic        dmarq, ddmardy_n, dstrobe, dd_oe, push_en, pop_en, busy, done;
    logic        fifo_empty;
    logic [15:0] dd_out, push_data, pop_data, sum_o;

    logic [15:0] src [64];
    logic [15:0] snk [64];
    logic [15:0] hrec [64];
    logic [15:0] exp_w [64];
    int src_n = 0, src_rd = 0, snk_n = 0, hn = 0, bad_oe = 0;
    int checks = 0, fails = 0;
    logic last_stb = 1'b1;

    always #10 clk = ~clk;

    assign fifo_empty = (src_rd >= src_n);
    assign pop_data   = src[src_rd[5:0]];

    udma_burst_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in), .word_cnt(word_cnt),
        .dmarq(dmarq), .dmack_n(dmack_n), .stop(stop), .hstrobe(hstrobe), .hrdy_n(hrdy_n),
        .dd_in(dd_in), .ddmardy_n(ddmardy_n), .dstrobe(dstrobe), .dd_out(dd_out),
        .dd_oe(dd_oe), .push_en(push_en), .push_data(push_data), .fifo_full(fifo_full),
        .pop_en(pop_en), .pop_data(pop_data), .fifo_empty(fifo_empty), .busy(busy),
        .done(done), .sum_o(sum_o)
    );

    // mid-cycle monitor; the source FIFO advances just after the capturing edge
    always begin
        logic p;
        @(negedge clk);
        #5;
        p = pop_en;
        if (push_en) begin snk[snk_n[5:0]] = push_data; snk_n++; end
        if (dstrobe !== last_stb) begin
            hrec[hn[5:0]] = dd_out; hn++;
            if (!dd_oe) bad_oe++;
        end
        last_stb = dstrobe;
        @(posedge clk);
        #1;
        if (p) src_rd++;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] sum_src(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + src[i];
        return s;
    endfunction

    function automatic logic [15:0] sum_snk(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + snk[i];
        return s;
    endfunction

    function automatic int mism_in(input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (hrec[i] !== src[i]) m++;
        return m;
    endfunction

    function automatic int mism_out(input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (snk[i] !== exp_w[i]) m++;
        return m;
    endfunction

    task automatic begin_burst(input logic d, input int cnt);
        @(negedge clk);
        start = 1'b1; dir_in = d; word_cnt = 16'(cnt);
        @(negedge clk);
        start = 1'b0;
        chk(dmarq === 1'b1, "R2 request after start", 32'(dmarq), 1);
    endtask

    task automatic wait_drop(input string rq);
        int k = 0;
        while (dmarq && k < 3000) begin @(negedge clk); k++; end
        chk(!dmarq, rq, 32'(dmarq), 0);
    endtask

    task automatic wait_hn(input int n);
        int k = 0;
        while (hn < n && k < 3000) begin @(negedge clk); k++; end
        chk(hn >= n, "R5 strobes arriving", hn, n);
    endtask

    task automatic end_burst(input logic d);
        bit seen = 0;
        logic [15:0] e;
        stop = 1'b1;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        stop = 1'b0;
        chk(seen, "R9 done after stop", 32'(seen), 1);
        chk(!busy && !dd_oe, "R9 idle after stop", {busy, dd_oe}, 0);
        if (d) chk(hn == src_rd, "R9 popped words all strobed", hn, src_rd);
        dmack_n = 1'b1;
        cyc(3);
        e = d ? sum_src(src_rd) : sum_snk(snk_n);
        chk(sum_o === e, "R10 checksum held", sum_o, e);
    endtask

    task automatic in_burst(input int cnt, input int nsrc);
        for (int i = 0; i < 64; i++) src[i] = 16'($urandom);
        src_n = nsrc; src_rd = 0; hn = 0; bad_oe = 0;
        hrdy_n = 1'b0;
        begin_burst(1'b1, cnt);
        cyc(8);
        chk(hn == 0 && src_rd == 0, "R2 no move before ack", hn, 0);
        dmack_n = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        int k = 0;
        while (ddmardy_n && k < 50) begin @(negedge clk); k++; end
        chk(!ddmardy_n, "R4 device ready", 32'(ddmardy_n), 0);
        dd_in = w; hstrobe = ~hstrobe;
        cyc(4);
    endtask

    task automatic out_burst(input int cnt, input int nsend);
        for (int i = 0; i < 64; i++) exp_w[i] = 16'($urandom);
        snk_n = 0;
        begin_burst(1'b0, cnt);
        dmack_n = 1'b0;
        for (int i = 0; i < nsend; i++) send_word(exp_w[i]);
        cyc(3);
    endtask

    initial begin
        int seed, h0, n;
        seed = $urandom(24681);
        last_stb = 1'b1;
        cyc(3);
        // R1 reset state
        chk(!dmarq && ddmardy_n && !dd_oe && dstrobe && !busy, "R1 reset values",
            {dmarq, ddmardy_n, dd_oe, dstrobe, busy}, 5'b01010);
        rst_n = 1'b1;
        cyc(2);

        // R2 zero count ignored
        @(negedge clk); start = 1'b1; dir_in = 1'b0; word_cnt = 16'd0;
        @(negedge clk); start = 1'b0;
        chk(!dmarq && !busy, "R2 zero count ignored", {dmarq, busy}, 0);

        // R3 / R8 directed host-to-device burst
        out_burst(5, 5);
        chk(snk_n == 5, "R3 push count", snk_n, 5);
        chk(mism_out(5) == 0, "R3 word order", mism_out(5), 0);
        chk(!dmarq && ddmardy_n, "R8 request drops at zero", {dmarq, ddmardy_n}, 2'b01);
        end_burst(1'b0);

        // R5 / R8 directed device-to-host burst
        in_burst(4, 4);
        wait_drop("R8 request drops at zero");
        cyc(4);
        chk(hn == 4, "R5 strobe count", hn, 4);
        chk(mism_in(4) == 0, "R5 data at strobe", mism_in(4), 0);
        chk(bad_oe == 0, "R5 bus driven at strobe", bad_oe, 0);
        end_burst(1'b1);

        // R6 host pause
        in_burst(8, 8);
        wait_hn(3);
        hrdy_n = 1'b1;
        cyc(4);
        h0 = hn;
        cyc(20);
        chk(hn == h0, "R6 no strobe while paused", hn, h0);
        chk(dmarq === 1'b1, "R6 request kept during pause", 32'(dmarq), 1);
        hrdy_n = 1'b0;
        wait_drop("R6 resume completes");
        cyc(4);
        chk(hn == 8 && mism_in(8) == 0, "R6 all words after resume", hn, 8);
        end_burst(1'b1);

        // R7 source runs empty
        in_burst(6, 3);
        wait_drop("R7 request drops on empty");
        cyc(6);
        chk(hn == 3, "R7 sent only available words", hn, 3);
        chk(busy === 1'b1, "R7 waits for stop", 32'(busy), 1);
        end_burst(1'b1);

        // R4 sink full
        out_burst(6, 2);
        fifo_full = 1'b1;
        cyc(3);
        chk(ddmardy_n && !dmarq, "R4 ready and request drop", {ddmardy_n, dmarq}, 2'b10);
        dd_in = 16'hdead; hstrobe = ~hstrobe;
        cyc(6);
        chk(snk_n == 2, "R4 edge while full ignored", snk_n, 2);
        fifo_full = 1'b0;
        end_burst(1'b0);

        // R9 stop in the middle of a device-to-host burst
        in_burst(20, 20);
        wait_hn(5);
        end_burst(1'b1);
        h0 = hn;
        cyc(10);
        chk(hn == h0, "R9 no strobe after stop", hn, h0);

        // random bursts
        for (int it = 0; it < 8; it++) begin
            n = 1 + int'($urandom % 40);
            if ($urandom % 2 == 1) begin
                in_burst(n, n);
                wait_drop("R8 random in drop");
                cyc(4);
                chk(hn == n && mism_in(n) == 0, "R5 random in burst", hn, n);
                end_burst(1'b1);
            end else begin
                out_burst(n, n);
                chk(snk_n == n && mism_out(n) == 0, "R3 random out burst", snk_n, n);
                end_burst(1'b0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule